// File: doc/BRIEF.md
# DMA Channel Address Sequencer with Destination Rewind

This block generates the read and write addresses for one DMA channel. The channel copies 32-bit words from a linear memory buffer into a small group of adjacent peripheral data registers. Each peripheral request starts a burst (a minor loop) of a fixed number of word moves, one per clock. Both addresses step by the word size on every move.

At the end of each burst the destination can be pulled back by a signed offset, so the same register group is written again. The source keeps moving forward through the buffer. When the programmed number of bursts has run, both addresses are adjusted by their own signed end-of-run offsets. These normally point them back at their starting values. The channel then switches itself off, so that further peripheral requests start nothing until software arms it again.

In use, software sets the configuration inputs and pulses `arm`. The peripheral raises `req` whenever its registers are empty. Bus arbitration and the data path are outside this block. Its strobes mark the cycles in which one word moves from `rd_addr` to `wr_addr`.

Top module: `dma_minor_addr_gen`

## Requirements
- R1: After reset the channel is disabled, both strobes are low, `rd_addr` and `wr_addr` are zero, `cur_iter` is zero and `major_done` is low.
- R2: An `arm` pulse while the channel is disabled and `cfg_iters` is non-zero does three things in the next cycle: it loads `rd_addr` from `cfg_src_base` and `wr_addr` from `cfg_dst_base`, it sets `cur_iter` to `cfg_iters`, and it raises `ch_enabled`. An `arm` with `cfg_iters` equal to zero is ignored. An `arm` while the channel is enabled is ignored, and the addresses keep their sequence.
- R3: A `req` sampled while the channel is enabled and idle produces exactly WORDS (default 4) consecutive cycles with `rd_stb` and `wr_stb` high, starting in the next cycle.
- R4: `rd_addr` rises by 4 bytes after every word move and carries on across burst boundaries. Within a run, the k-th word (counting from 0) reads `cfg_src_base + 4k`.
- R5: When both `cfg_off_map` and `cfg_off_dst` are 1, `wr_addr` rises by 4 after each move, and at the end of a burst that does not finish the run it becomes `wr_addr + 4 + cfg_dst_burst_off`. With an offset of -16 the k-th word is written to `cfg_dst_base + 4*(k mod 4)`.
- R6: When either `cfg_off_map` or `cfg_off_dst` is 0, no burst offset is applied and the k-th word is written to `cfg_dst_base + 4k`.
- R7: `cur_iter` drops by one at the end of each burst that does not finish the run.
- R8: On the last move of the final burst, `rd_addr` becomes `rd_addr + 4 + cfg_src_end_off` and `wr_addr` becomes `wr_addr + 4 + cfg_dst_end_off`; the end offset replaces the burst offset. In the next cycle `major_done` is high for exactly one cycle, `ch_enabled` is low and `cur_iter` shows the count that was armed.
- R9: Requests that arrive during a burst are held as a single pending request. If one is held, or `req` is high in the burst's last cycle, the next burst follows with no idle cycle.
- R10: While the channel is disabled, `req` produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Enable pulse from software |
| req | input | 1 | Peripheral service request |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_iters | input | CNT_W | Number of bursts per run |
| cfg_src_end_off | input | ADDR_W | Signed source adjustment at end of run |
| cfg_dst_end_off | input | ADDR_W | Signed destination adjustment at end of run |
| cfg_dst_burst_off | input | ADDR_W | Signed destination adjustment after each burst |
| cfg_off_map | input | 1 | Burst-offset mapping enable |
| cfg_off_dst | input | 1 | Apply burst offset to destination |
| rd_addr | output | ADDR_W | Current source address |
| wr_addr | output | ADDR_W | Current destination address |
| rd_stb | output | 1 | Read of `rd_addr` this cycle |
| wr_stb | output | 1 | Write of `wr_addr` this cycle |
| ch_enabled | output | 1 | Channel armed |
| major_done | output | 1 | One-cycle pulse after the final burst |
| cur_iter | output | CNT_W | Bursts remaining |

## Verification
A wrong beat counter shows up within one burst as a strobe run that is not WORDS cycles long. A lost pending request shows up as an idle cycle between bursts, or as a run that never completes. A destination that misses its burst rewind is off by 16 bytes on the first move of the second burst. A source that wrongly takes that rewind repeats addresses at the same point. If the end-of-run offset is misapplied, or the iteration count is not reloaded, the fault appears in the cycle of `major_done`: the addresses are not back at their bases, or `cur_iter` differs from the armed count.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  typedef enum logic [1:0] {
    CH_OFF  = 2'd0,
    CH_WAIT = 2'd1,
    CH_MOVE = 2'd2
  } ch_state_e;
endpackage

// File: rtl/dmag_seq.sv
module dmag_seq
  import dmag_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             req_i,
  input  logic [CNT_W-1:0] iters_i,
  output logic             load_o,
  output logic             beat_o,
  output logic             minor_end_o,
  output logic             major_end_o,
  output logic             en_o,
  output logic [CNT_W-1:0] iter_o,
  output logic             done_o
);
  localparam int BEAT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);
  localparam logic [CNT_W-1:0]  ONE_ITER  = CNT_W'(1);

  ch_state_e         state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [CNT_W-1:0]  iter_q, iter_d, biter_q, biter_d;
  logic              pend_q, pend_d, done_q, done_d;
  logic              last_beat;

  assign last_beat   = (beat_q == LAST_BEAT);
  assign beat_o      = (state_q == CH_MOVE);
  assign minor_end_o = beat_o && last_beat;
  assign major_end_o = minor_end_o && (iter_q == ONE_ITER);
  assign en_o        = (state_q != CH_OFF);
  assign iter_o      = iter_q;
  assign done_o      = done_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    iter_d  = iter_q;
    biter_d = biter_q;
    pend_d  = pend_q;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      CH_OFF: begin
        if (arm_i && (iters_i != '0)) begin
          state_d = CH_WAIT;
          iter_d  = iters_i;
          biter_d = iters_i;
          pend_d  = 1'b0;
          beat_d  = '0;
          load_o  = 1'b1;
        end
      end
      CH_WAIT: begin
        if (req_i) begin
          state_d = CH_MOVE;
          beat_d  = '0;
        end
      end
      CH_MOVE: begin
        if (last_beat) begin
          beat_d = '0;
          pend_d = 1'b0;
          if (iter_q == ONE_ITER) begin
            state_d = CH_OFF;
            iter_d  = biter_q;
            done_d  = 1'b1;
          end else begin
            iter_d  = iter_q - ONE_ITER;
            state_d = (pend_q || req_i) ? CH_MOVE : CH_WAIT;
          end
        end else begin
          beat_d = beat_q + BEAT_W'(1);
          if (req_i) pend_d = 1'b1;
        end
      end
      default: state_d = CH_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CH_OFF;
      beat_q  <= '0;
      iter_q  <= '0;
      biter_q <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
      iter_q  <= iter_d;
      biter_q <= biter_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8
  iter_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    major_end_o |=> (iter_o == $past(biter_q)) && !en_o);
  // R9
  hold_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (minor_end_o && !major_end_o && pend_q) |=> beat_o);
  // R10
  off_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o) |=> !beat_o);
endmodule

// File: rtl/dmag_addr_reg.sv
module dmag_addr_reg #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              step_i,
  input  logic              minor_end_i,
  input  logic              major_end_i,
  input  logic              burst_en_i,
  input  logic [ADDR_W-1:0] burst_off_i,
  input  logic [ADDR_W-1:0] end_off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] addr_q, addr_d, adj;
  logic              addr_en;

  always_comb begin
    if (major_end_i)                    adj = end_off_i;
    else if (minor_end_i && burst_en_i) adj = burst_off_i;
    else                                adj = '0;
    addr_en = load_i || step_i;
    addr_d  = load_i ? base_i : (addr_q + STEP_V + adj);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R4
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !minor_end_i && !load_i) |=> addr_o == $past(addr_o) + STEP_V);
  // R8
  end_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    major_end_i |=> addr_o == $past(addr_o) + STEP_V + $past(end_off_i));
endmodule

// File: rtl/dma_minor_addr_gen.sv
module dma_minor_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int CNT_W      = 16,
  parameter int WORDS      = 4,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              req,
  input  logic [ADDR_W-1:0] cfg_src_base,
  input  logic [ADDR_W-1:0] cfg_dst_base,
  input  logic [CNT_W-1:0]  cfg_iters,
  input  logic [ADDR_W-1:0] cfg_src_end_off,
  input  logic [ADDR_W-1:0] cfg_dst_end_off,
  input  logic [ADDR_W-1:0] cfg_dst_burst_off,
  input  logic              cfg_off_map,
  input  logic              cfg_off_dst,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              ch_enabled,
  output logic              major_done,
  output logic [CNT_W-1:0]  cur_iter
);
  localparam int NCH = 2; // index 0 source, 1 destination

  logic load, beat, minor_end, major_end;
  logic [ADDR_W-1:0] base_a [NCH];
  logic [ADDR_W-1:0] eoff_a [NCH];
  logic [ADDR_W-1:0] addr_a [NCH];
  logic              ben_a  [NCH];

  assign base_a[0] = cfg_src_base;
  assign base_a[1] = cfg_dst_base;
  assign eoff_a[0] = cfg_src_end_off;
  assign eoff_a[1] = cfg_dst_end_off;
  assign ben_a[0]  = 1'b0;
  assign ben_a[1]  = cfg_off_map && cfg_off_dst;

  dmag_seq #(.WORDS(WORDS), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .req_i(req), .iters_i(cfg_iters),
    .load_o(load), .beat_o(beat), .minor_end_o(minor_end),
    .major_end_o(major_end), .en_o(ch_enabled), .iter_o(cur_iter),
    .done_o(major_done)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_addr
    dmag_addr_reg #(.ADDR_W(ADDR_W), .STEP(WORD_BYTES)) u_addr (
      .clk(clk), .rst_n(rst_n), .load_i(load), .base_i(base_a[g]),
      .step_i(beat), .minor_end_i(minor_end), .major_end_i(major_end),
      .burst_en_i(ben_a[g]), .burst_off_i(cfg_dst_burst_off),
      .end_off_i(eoff_a[g]), .addr_o(addr_a[g])
    );
  end

  assign rd_addr = addr_a[0];
  assign wr_addr = addr_a[1];
  assign rd_stb  = beat;
  assign wr_stb  = beat;

  // R10
  quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_enabled |-> !rd_stb && !wr_stb);
  // R3
  req_starts_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_enabled && !rd_stb && req) |=> rd_stb);
endmodule

// File: tb/dma_minor_addr_gen_tb.sv
module dma_minor_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, arm, req, cfg_off_map, cfg_off_dst;
  logic [31:0] cfg_src_base, cfg_dst_base, cfg_src_end_off, cfg_dst_end_off, cfg_dst_burst_off;
  logic [15:0] cfg_iters;
  logic [31:0] rd_addr, wr_addr;
  logic rd_stb, wr_stb, ch_enabled, major_done;
  logic [15:0] cur_iter;

  int tests = 0, fails = 0;
  bit finished = 0;
  // reference state
  bit m_en, m_busy, m_pend, m_done, m_wrap;
  int m_beat, m_iter, m_biter, m_k;
  logic [31:0] run_src, run_dst;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_minor_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .req(req),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base), .cfg_iters(cfg_iters),
    .cfg_src_end_off(cfg_src_end_off), .cfg_dst_end_off(cfg_dst_end_off),
    .cfg_dst_burst_off(cfg_dst_burst_off), .cfg_off_map(cfg_off_map),
    .cfg_off_dst(cfg_off_dst), .rd_addr(rd_addr), .wr_addr(wr_addr),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .ch_enabled(ch_enabled),
    .major_done(major_done), .cur_iter(cur_iter)
  );

  function automatic logic [31:0] exp_src();
    return run_src + 32'(4 * m_k);
  endfunction
  function automatic logic [31:0] exp_dst();
    return m_wrap ? run_dst + 32'(4 * (m_k % 4)) : run_dst + 32'(4 * m_k);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: compare outputs, drive inputs, advance reference model
  task automatic cyc(input bit a, input bit r);
    arm = a; req = r;
    check(rd_stb == m_busy && wr_stb == m_busy, m_en ? "R3 R9 strobe" : "R10 strobe while off",
          {30'd0, rd_stb, wr_stb}, {30'd0, m_busy, m_busy});
    check(ch_enabled == m_en, "R2 R8 enable", {31'd0, ch_enabled}, {31'd0, m_en});
    check(cur_iter == 16'(m_iter), "R7 R8 iteration count", {16'd0, cur_iter}, 32'(m_iter));
    check(major_done == m_done, "R8 done pulse", {31'd0, major_done}, {31'd0, m_done});
    if (m_en || m_done) begin
      check(rd_addr == exp_src(), "R4 R8 source address", rd_addr, exp_src());
      check(wr_addr == exp_dst(), m_wrap ? "R5 R8 destination address" : "R6 R8 destination address",
            wr_addr, exp_dst());
    end
    @(posedge clk);
    m_done = 0;
    if (!m_en) begin
      if (a && cfg_iters != 0) begin
        m_en = 1; m_iter = cfg_iters; m_biter = cfg_iters; m_k = 0;
        m_busy = 0; m_pend = 0; m_beat = 0;
        run_src = cfg_src_base; run_dst = cfg_dst_base;
        m_wrap = cfg_off_map && cfg_off_dst;
      end
    end else if (!m_busy) begin
      if (r) begin m_busy = 1; m_beat = 0; end
    end else begin
      m_k++;
      if (m_beat == 3) begin
        if (m_iter == 1) begin
          m_en = 0; m_busy = 0; m_done = 1; m_iter = m_biter; m_k = 0; m_pend = 0;
        end else begin
          m_iter--; m_busy = m_pend || r; m_pend = 0; m_beat = 0;
        end
      end else begin
        m_beat++;
        if (r) m_pend = 1;
      end
    end
    @(negedge clk);
  endtask

  // mode 0 random requests, 1 request every cycle, 2 sparse requests
  task automatic run(input logic [31:0] src, input logic [31:0] dst, input int iters,
                     input bit map, input bit dsel, input int mode);
    int guard;
    cfg_src_base = src; cfg_dst_base = dst; cfg_iters = 16'(iters);
    cfg_off_map = map; cfg_off_dst = dsel; cfg_dst_burst_off = -32'sd16;
    cfg_src_end_off = 32'd0 - 32'(16 * iters);
    cfg_dst_end_off = (map && dsel) ? -32'sd16 : 32'd0 - 32'(16 * iters);
    cyc(1'b1, 1'b0);
    guard = 0;
    while (m_en && guard < 2000) begin
      bit r, a;
      r = (mode == 1) ? 1'b1 : (mode == 2) ? (guard % 7 == 0) : 1'($urandom % 2);
      a = ($urandom % 16 == 0); // R2: arm while enabled must be ignored
      if (a) cfg_src_base = $urandom;
      cyc(a, r);
      guard++;
    end
    cyc(1'b0, 1'b1); // done cycle checked, R10 request after self-disable
    cyc(1'b0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    arm = 0; req = 0; rst_n = 0;
    cfg_src_base = 0; cfg_dst_base = 0; cfg_iters = 0; cfg_off_map = 0; cfg_off_dst = 0;
    cfg_src_end_off = 0; cfg_dst_end_off = 0; cfg_dst_burst_off = 0;
    m_en = 0; m_busy = 0; m_pend = 0; m_done = 0; m_wrap = 0;
    m_beat = 0; m_iter = 0; m_biter = 0; m_k = 0; run_src = 0; run_dst = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(rd_addr == 0 && wr_addr == 0, "R1 reset addresses", rd_addr | wr_addr, 32'd0);
    check(!rd_stb && !wr_stb && !ch_enabled && !major_done && cur_iter == 0, "R1 reset controls",
          {27'd0, rd_stb, wr_stb, ch_enabled, major_done, |cur_iter}, 32'd0);
    // R10 requests while never armed
    repeat (4) cyc(1'b0, 1'b1);
    // R2 arm with zero count is ignored
    cfg_iters = 0; cyc(1'b1, 1'b0); cyc(1'b0, 1'b1);
    // directed corners
    run(32'h0000_1000, 32'h4000_0000, 3, 1, 1, 2);   // R5 rewind, sparse requests
    run(32'h0000_2000, 32'h4000_0040, 4, 1, 1, 1);   // R9 back-to-back
    run(32'h0000_3000, 32'h4000_0080, 3, 1, 0, 1);   // R6 mapping on, destination not selected
    run(32'h0000_3800, 32'h4000_00C0, 2, 0, 1, 0);   // R6 mapping off
    run(32'hFFFF_FFF0, 32'h4000_0100, 1, 1, 1, 0);   // R8 single burst, source wraps
    // random runs
    for (int i = 0; i < 30; i++) begin
      run($urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC, 1 + int'($urandom % 8),
          1'($urandom % 4 != 0), 1'($urandom % 4 != 0), int'($urandom % 3));
      repeat (int'($urandom % 3)) cyc(1'b0, 1'($urandom % 2));
    end
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule